// File: doc/BRIEF.md
# Fixed-Point to Floating-Point Converter

This block turns a signed two's-complement fixed-point word into a packed binary floating-point word made of a sign, a biased exponent and a stored mantissa. The width of the fixed word and the widths of the float fields are parameters. The defaults are a 32-bit fixed word and single precision (1 sign bit, 8 exponent bits, 23 mantissa bits). The position of the binary point in the fixed word is the number of fractional bits. It can come from a per-word input, so one instance serves every fixed format of its width. It can also be fixed at build time by a parameter, and the input pin is then ignored.

The conversion takes the magnitude of the input and locates its most significant one. A left shift moves that one to the top of the word. The exponent is the one's position minus the binary point, plus the bias. Bits below the mantissa field are dropped without rounding. A zero input gives positive zero. An exponent too large for the field gives a signed infinity. An exponent too small for a normal number gives a zero carrying the input's sign, because denormals are not produced.

Words enter on a valid/ready port and leave on a valid/ready port through one output register. A word is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or its word is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new word is taken.

Top module: `fx2fp_conv`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a word is accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_flt` and `out_valid` hold, and `in_ready` is low. When the stall ends, the held word is delivered first.
- R3: A fixed input of zero produces the all-zero float word (positive zero).
- R4: The float sign bit (bit FLT_W-1) equals the fixed input's MSB. A positive value and its negation differ only in that bit.
- R5: The exponent field (bits FLT_W-2 down to MAN_W) equals the leading-one index of the magnitude, minus the binary point, plus the bias 2^(EXP_W-1)-1.
- R6: The mantissa field (bits MAN_W-1 down to 0) is the MAN_W bits just below the leading one. Lower bits are dropped with no rounding: 0x7FFFFFFF at point 0 gives 0x4EFFFFFF.
- R7: The most negative fixed value converts with its magnitude taken as unsigned: 0x80000000 at point 0 gives 0xCF000000.
- R8: A biased exponent of 2^EXP_W-1 or more gives infinity. Infinity has the input's sign, an all-ones exponent and a zero mantissa.
- R9: A biased exponent of zero or less gives zero with the input's sign.
- R10: With `RP_RUNTIME`=1 the binary point is taken from `in_rp` with each word. With `RP_RUNTIME`=0 the point is `RP_FIXED` and `in_rp` has no effect on the output.
- R11: A word accepted at one edge appears on `out_flt` with `out_valid` high after that edge. Words leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_fix | input | FIX_W | Signed fixed-point input |
| in_rp | input | RP_W | Fractional bit count for this word (runtime mode) |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_flt | output | FLT_W | Packed float {sign, exponent, mantissa} |

## Verification
Exact powers of two at several binary points pin the exponent arithmetic on its own, because their mantissa is zero. Values such as 1.5 and 3.0 check that the field below the leading one is placed correctly. All-ones and most-negative patterns separate truncation from rounding and separate an unsigned magnitude from a signed one. A second, narrow-exponent instance with a fixed point is driven with leading ones one step on either side of the overflow and underflow limits while `in_rp` is toggled. A pseudo-random sweep compares against a bench model, and a stalled output checks hold and ordering.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;
  function automatic int flt_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

  function automatic int flt_emax(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction
endpackage

// File: rtl/fx2fp_lead.sv
module fx2fp_lead #(
  parameter int FIX_W = 32,
  localparam int IW = $clog2(FIX_W)
) (
  input  logic [FIX_W-1:0] mag,
  output logic [IW-1:0]    lead,
  output logic             nz
);
  always_comb begin
    lead = '0;
    nz   = 1'b0;
    for (int i = 0; i < FIX_W; i++) begin
      if (mag[i]) begin
        lead = i[IW-1:0];
        nz   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fx2fp_norm.sv
module fx2fp_norm #(
  parameter int FIX_W = 32,
  parameter int MAN_W = 23,
  localparam int IW = $clog2(FIX_W)
) (
  input  logic [FIX_W-1:0] mag,
  input  logic [IW-1:0]    lead,
  output logic [MAN_W-1:0] mant
);
  logic [IW-1:0]    shl;
  logic [FIX_W-1:0] aligned;

  assign shl     = IW'(FIX_W - 1) - lead;
  assign aligned = mag << shl;

  generate
    if (FIX_W - 1 >= MAN_W) begin : g_trunc
      assign mant = aligned[FIX_W-2 -: MAN_W];
    end else begin : g_pad
      assign mant = {aligned[FIX_W-2:0], {(MAN_W - FIX_W + 1){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/fx2fp_exp.sv
module fx2fp_exp #(
  parameter int FIX_W = 32,
  parameter int RP_W  = 6,
  parameter int EXP_W = 8,
  localparam int IW = $clog2(FIX_W),
  localparam int CW = EXP_W + RP_W + IW + 2
) (
  input  logic [IW-1:0]    lead,
  input  logic [RP_W-1:0]  rp,
  output logic [EXP_W-1:0] exp_f,
  output logic             ovf,
  output logic             unf
);
  import fx2fp_pkg::*;
  localparam int BIAS = flt_bias(EXP_W);
  localparam int EMAX = flt_emax(EXP_W);

  logic signed [CW-1:0] e_s;

  assign e_s   = $signed(CW'(lead)) - $signed(CW'(rp)) + $signed(CW'(BIAS));
  assign ovf   = e_s >= $signed(CW'(EMAX));
  assign unf   = e_s <= $signed(CW'(0));
  assign exp_f = e_s[EXP_W-1:0];
endmodule

// File: rtl/fx2fp_conv.sv
module fx2fp_conv #(
  parameter int FIX_W      = 32,
  parameter int RP_W       = 6,
  parameter int FLT_W      = 32,
  parameter int EXP_W      = 8,
  parameter int MAN_W      = 23,
  parameter bit RP_RUNTIME = 1'b1,
  parameter int RP_FIXED   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FIX_W-1:0] in_fix,
  input  logic [RP_W-1:0]  in_rp,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FLT_W-1:0] out_flt
);
  localparam int IW = $clog2(FIX_W);

  generate
    if (FLT_W != 1 + EXP_W + MAN_W) begin : g_bad_width
      $error("FLT_W must equal 1 + EXP_W + MAN_W");
    end
  endgenerate

  logic             sgn;
  logic [FIX_W-1:0] mag;
  logic [IW-1:0]    lead;
  logic             nz;
  logic [MAN_W-1:0] mant;
  logic [EXP_W-1:0] exp_f;
  logic             ovf, unf;
  logic [RP_W-1:0]  rp_eff;
  logic [FLT_W-1:0] flt_d;
  logic             take;

  assign sgn    = in_fix[FIX_W-1];
  assign mag    = sgn ? (~in_fix + 1'b1) : in_fix;
  assign rp_eff = RP_RUNTIME ? in_rp : RP_W'(RP_FIXED);

  fx2fp_lead #(.FIX_W(FIX_W)) u_lead (
    .mag (mag),
    .lead(lead),
    .nz  (nz)
  );

  fx2fp_norm #(.FIX_W(FIX_W), .MAN_W(MAN_W)) u_norm (
    .mag (mag),
    .lead(lead),
    .mant(mant)
  );

  fx2fp_exp #(.FIX_W(FIX_W), .RP_W(RP_W), .EXP_W(EXP_W)) u_exp (
    .lead (lead),
    .rp   (rp_eff),
    .exp_f(exp_f),
    .ovf  (ovf),
    .unf  (unf)
  );

  always_comb begin
    if (!nz)
      flt_d = '0;
    else if (ovf)
      flt_d = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (unf)
      flt_d = {sgn, {(FLT_W-1){1'b0}}};
    else
      flt_d = {sgn, exp_f, mant};
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flt   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_flt   <= flt_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fx2fp_conv_chk.sv
module fx2fp_conv_chk #(
  parameter int FIX_W = 32,
  parameter int FLT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FIX_W-1:0] in_fix,
  input logic             out_valid,
  input logic             out_ready,
  input logic [FLT_W-1:0] out_flt
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flt)));

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_fix == '0) |=> (out_flt == '0));

  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_flt[FLT_W-1] == $past(in_fix[FIX_W-1])));

  a_r8_inf_mant: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_flt[FLT_W-2 -: EXP_W])) |-> (out_flt[MAN_W-1:0] == '0));
endmodule

bind fx2fp_conv fx2fp_conv_chk #(
  .FIX_W(FIX_W), .FLT_W(FLT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_fix   (in_fix),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_flt  (out_flt)
);

// File: tb/fx2fp_conv_test.sv
module fx2fp_conv_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // default instance: 32-bit fixed, single precision, runtime point
  logic        a_iv = 1'b0, a_ir, a_ov, a_or = 1'b1;
  logic [31:0] a_fix = '0, a_flt;
  logic [5:0]  a_rp = '0;

  fx2fp_conv uut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
    .in_fix(a_fix), .in_rp(a_rp), .out_valid(a_ov), .out_ready(a_or),
    .out_flt(a_flt)
  );

  // narrow instance: 40-bit fixed, 1/5/10 float, point fixed at 20
  logic        b_iv = 1'b0, b_ir, b_ov, b_or = 1'b1;
  logic [39:0] b_fix = '0;
  logic [15:0] b_flt;
  logic [5:0]  b_rp = '0;

  fx2fp_conv #(
    .FIX_W(40), .RP_W(6), .FLT_W(16), .EXP_W(5), .MAN_W(10),
    .RP_RUNTIME(1'b0), .RP_FIXED(20)
  ) uut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir),
    .in_fix(b_fix), .in_rp(b_rp), .out_valid(b_ov), .out_ready(b_or),
    .out_flt(b_flt)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_sp(input logic [31:0] d, input int r);
    logic [31:0] m;
    logic [63:0] w;
    int ld;
    int e;
    m = d[31] ? (~d + 32'd1) : d;
    if (m == 0) return 32'h0;
    ld = 31;
    while (!m[ld]) ld--;
    e = ld - r + 127;
    w = {32'h0, m} << (63 - ld);
    return {d[31], e[7:0], w[62:40]};
  endfunction

  task automatic send_a(input logic [31:0] d, input logic [5:0] r,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    a_iv = 1'b1; a_fix = d; a_rp = r;
    @(posedge clk);
    @(negedge clk);
    a_iv = 1'b0;
    check(a_ov === 1'b1 && a_flt === exp, req, {32'h0, a_flt}, {32'h0, exp});
  endtask

  task automatic send_b(input logic [39:0] d, input logic [5:0] r,
                        input logic [15:0] exp, input string req);
    @(negedge clk);
    b_iv = 1'b1; b_fix = d; b_rp = r;
    @(posedge clk);
    @(negedge clk);
    b_iv = 1'b0;
    check(b_ov === 1'b1 && b_flt === exp, req, {48'h0, b_flt}, {48'h0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(a_ov === 1'b0, "R1 out_valid after reset", {63'h0, a_ov}, 64'h0);
    check(b_ov === 1'b0, "R1 small out_valid after reset", {63'h0, b_ov}, 64'h0);
    check(a_ir === 1'b1, "R2 in_ready when empty", {63'h0, a_ir}, 64'h1);
  endtask

  task automatic t_basic;
    send_a(32'h0, 6'd16, 32'h0000_0000, "R3 zero input");
    send_a(32'h0001_0000, 6'd16, 32'h3F80_0000, "R5 one at point 16");
    send_a(32'hFFFE_8000, 6'd16, 32'hBFC0_0000, "R4 minus 1.5");
    send_a(32'h0001_8000, 6'd16, 32'h3FC0_0000, "R4 plus 1.5");
    send_a(32'h0000_0003, 6'd0, 32'h4040_0000, "R5 three at point 0");
    send_a(32'h0000_0001, 6'd31, 32'h3000_0000, "R5 2^-31");
  endtask

  task automatic t_trunc;
    send_a(32'h7FFF_FFFF, 6'd0, 32'h4EFF_FFFF, "R6 all ones truncated");
    send_a(32'h0000_0001 | 32'h4000_0000, 6'd0, 32'h4E80_0000, "R6 low bit dropped");
  endtask

  task automatic t_minneg;
    send_a(32'h8000_0000, 6'd0, 32'hCF00_0000, "R7 most negative point 0");
    send_a(32'h8000_0000, 6'd31, 32'hBF80_0000, "R7 most negative point 31");
  endtask

  task automatic t_runtime_rp;
    send_a(32'h0000_0100, 6'd8, 32'h3F80_0000, "R10 point 8");
    send_a(32'h0000_0100, 6'd0, 32'h4380_0000, "R10 point 0 same word");
  endtask

  task automatic t_limits;
    send_b(40'h00_0010_0000, 6'd0, 16'h3C00, "R10 fixed point ignores in_rp");
    send_b(40'h00_0010_0000, 6'd63, 16'h3C00, "R10 fixed point ignores in_rp 63");
    send_b(40'h08_0000_0000, 6'd0, 16'h7800, "R5 largest finite exponent");
    send_b(40'h10_0000_0000, 6'd0, 16'h7C00, "R8 positive infinity");
    send_b(40'h80_0000_0000, 6'd0, 16'hFC00, "R8 negative infinity");
    send_b(40'h00_0000_0040, 6'd0, 16'h0400, "R9 smallest normal");
    send_b(40'h00_0000_0020, 6'd0, 16'h0000, "R9 underflow to zero");
    send_b(40'hFF_FFFF_FFFF, 6'd0, 16'h8000, "R9 underflow negative zero");
  endtask

  task automatic t_stall;
    @(negedge clk);
    a_or = 1'b0;
    a_iv = 1'b1; a_fix = 32'h0001_0000; a_rp = 6'd16;
    @(posedge clk);
    @(negedge clk);
    a_fix = 32'h0002_0000;
    check(a_ir === 1'b0, "R2 in_ready low while stalled", {63'h0, a_ir}, 64'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(a_ov === 1'b1 && a_flt === 32'h3F80_0000, "R2 word held", {32'h0, a_flt},
          64'h3F80_0000);
    a_or = 1'b1;
    @(posedge clk);
    @(negedge clk);
    a_iv = 1'b0;
    check(a_ov === 1'b1 && a_flt === 32'h4000_0000, "R11 second word in order",
          {32'h0, a_flt}, 64'h4000_0000);
    @(posedge clk);
    @(negedge clk);
    check(a_ov === 1'b0, "R11 drained", {63'h0, a_ov}, 64'h0);
  endtask

  task automatic t_sweep;
    logic [31:0] d;
    d = 32'h1357_9BDF;
    for (int k = 0; k < 24; k++) begin
      d = d * 32'd1103515245 + 32'd12345;
      send_a(d >> (k % 17), 6'((k * 7) % 40), ref_sp(d >> (k % 17), (k * 7) % 40),
             "R5 R6 sweep");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_trunc();
    t_minneg();
    t_runtime_rp();
    t_limits();
    t_stall();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule